// File: doc/BRIEF.md
# Double-Buffered DAC Command Controller

This block sits behind a serial receive front end and turns each completed 24-bit word into actions on a two-stage register pair feeding a digital-to-analog converter. A staging register takes new codes; a second, output register holds the code the converter actually sees. A 4-bit command in the word chooses between staging a code, moving the staged code to the output, doing both, putting the converter to sleep, or nothing.

Next to the command path sits an active-low update strobe. On a high-to-low transition it copies the staged code to the output, but only when a fully received word is waiting. The same transition always wakes the converter. If the strobe is already low when a word completes, the word's command runs and is followed at once by an output update, and any sleep request in that word is dropped. Leaving sleep lowers a ready flag for a set number of clocks, which stands for the analog wake-up time.

The resolution (12, 14 or 16 bits) and the reset code (zero or mid-scale) are parameters. The wake-up delay is a cycle count: about 12 us at a 200 MHz clock by default.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset both registers hold zero, or only the code MSB set when MID_RESET=1. The converter is awake and ready_o is high.
- R2: The command is word bits 23:20. The code is taken left-aligned from bit 15 downward, RES_BITS wide. Bits 19:16 and the bits below the code are ignored.
- R3: Command 4'b0000 loads the staging register and leaves the output code unchanged.
- R4: Command 4'b0001 copies the staging register to the output and wakes the converter. Its data field is ignored.
- R5: Command 4'b0011 loads the staging register with the word's code and puts that same code on the output in the same cycle, then wakes the converter.
- R6: Command 4'b0100 puts the converter to sleep (pwr_dn_o high) and leaves both registers and the output code unchanged.
- R7: Command 4'b1111 and every code not named in R3 to R6 change nothing.
- R8: A high-to-low transition of upd_n_i copies the staging register to the output only if a complete word has arrived since the last update and no new transfer has begun. Without such a word, the output is unchanged.
- R9: A high-to-low transition of upd_n_i while rx_busy_i is high wakes the converter but leaves the output code unchanged.
- R10: If upd_n_i is low when a word completes, the command runs and the output then takes the staging value. A sleep command in that word has no effect.
- R11: When the converter leaves sleep, ready_o is low for exactly WAKE_CYCLES clocks, then returns high. ready_o is low throughout sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_i | input | 24 | Received command word |
| word_vld_i | input | 1 | One-cycle strobe: word_i is complete |
| rx_busy_i | input | 1 | High while a word is being shifted in |
| upd_n_i | input | 1 | Active-low update strobe, synchronous to clk |
| dac_code_o | output | RES_BITS | Output register contents fed to the converter |
| pwr_dn_o | output | 1 | Converter in sleep |
| ready_o | output | 1 | Converter awake and settled |

## Verification
The assertions assume upd_n_i is already synchronous to clk. They also assume word_vld_i is a single-cycle pulse and never coincides with rx_busy_i, which is what a well-formed front end gives. The stimulus changes every input only at the falling clock edge. It pulses word_vld_i for one cycle with rx_busy_i low, and raises rx_busy_i only between words. Under these rules a falling upd_n_i edge is seen as exactly one clock's transition, which is the case the update properties relate to.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    localparam int WORD_W   = 24;
    localparam int CMD_MSB  = 23;
    localparam int CMD_LSB  = 20;
    localparam int CMD_W    = CMD_MSB - CMD_LSB + 1;
    localparam int DATA_MSB = 15;

    typedef enum logic [CMD_W-1:0] {
        CMD_STAGE  = 4'b0000,
        CMD_COMMIT = 4'b0001,
        CMD_STGCOM = 4'b0011,
        CMD_SLEEP  = 4'b0100,
        CMD_IDLE   = 4'b1111
    } dac_cmd_e;

    typedef struct packed {
        logic load;
        logic update;
        logic sleep;
    } cmd_act_t;

    // Reserved codes fall through to no action.
    function automatic cmd_act_t decode_cmd(input logic [CMD_W-1:0] c);
        cmd_act_t a;
        a = '0;
        case (c)
            CMD_STAGE:  a.load = 1'b1;
            CMD_COMMIT: a.update = 1'b1;
            CMD_STGCOM: begin a.load = 1'b1; a.update = 1'b1; end
            CMD_SLEEP:  a.sleep = 1'b1;
            default:    a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/dac_word_decode.sv
module dac_word_decode
    import dac_cmd_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic [WORD_W-1:0]   word_i,
    output cmd_act_t            act_o,
    output logic [RES_BITS-1:0] code_o
);
    localparam int PAD_W = 16 - RES_BITS;

    assign act_o  = decode_cmd(word_i[CMD_MSB:CMD_LSB]);
    assign code_o = word_i[DATA_MSB -: RES_BITS];

    logic unused_fill;
    generate
        if (PAD_W > 0) begin : g_pad
            assign unused_fill = ^{word_i[19:16], word_i[PAD_W-1:0]};
        end else begin : g_nopad
            assign unused_fill = ^word_i[19:16];
        end
    endgenerate

endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
    import dac_cmd_pkg::*;
#(
    parameter int RES_BITS  = 16,
    parameter bit MID_RESET = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vld_i,
    input  cmd_act_t            act_i,
    input  logic [RES_BITS-1:0] code_i,
    input  logic                busy_i,
    input  logic                upd_n_i,
    output logic [RES_BITS-1:0] dac_o,
    output logic                pwr_dn_o,
    output logic                wake_req_o
);
    localparam logic [RES_BITS-1:0] RST_CODE =
        MID_RESET ? {1'b1, {(RES_BITS-1){1'b0}}} : '0;

    logic [RES_BITS-1:0] stage_q, stage_d, dac_q, dac_d;
    logic                pd_q, pd_d, pend_q, pend_d, upd_q;
    logic                upd_low, upd_fall, pend_eff;

    assign upd_low  = ~upd_n_i;
    assign upd_fall = upd_q & ~upd_n_i;
    assign pend_eff = pend_q & ~busy_i;

    always_comb begin
        stage_d = stage_q;
        dac_d   = dac_q;
        pd_d    = pd_q;
        pend_d  = busy_i ? 1'b0 : pend_q;
        if (vld_i) begin
            if (act_i.load) stage_d = code_i;
            if (act_i.update || upd_low) begin
                dac_d = act_i.load ? code_i : stage_q;
                pd_d  = 1'b0;
            end else if (act_i.sleep) begin
                pd_d = 1'b1;
            end
            pend_d = ~upd_low;
        end else if (upd_fall) begin
            pd_d = 1'b0;
            if (pend_eff) begin
                dac_d  = stage_q;
                pend_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= RST_CODE;
            dac_q   <= RST_CODE;
            pd_q    <= 1'b0;
            pend_q  <= 1'b0;
            upd_q   <= 1'b1;
        end else begin
            stage_q <= stage_d;
            dac_q   <= dac_d;
            pd_q    <= pd_d;
            pend_q  <= pend_d;
            upd_q   <= upd_n_i;
        end
    end

    assign dac_o      = dac_q;
    assign pwr_dn_o   = pd_q;
    assign wake_req_o = pd_q & ~pd_d;

    // R10: a sleep request is dropped while the strobe is low
    assert_sleep_dropped_R10: assert property (@(posedge clk) disable iff (rst)
        (vld_i && act_i.sleep && !upd_n_i) |=> !pwr_dn_o);

    // R6: sleep keeps both registers
    assert_sleep_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (vld_i && act_i.sleep && upd_n_i) |=> (pwr_dn_o && $stable(dac_q) && $stable(stage_q)));

    // R3: staging alone never moves the output
    assert_stage_only_R3: assert property (@(posedge clk) disable iff (rst)
        (vld_i && act_i.load && !act_i.update && upd_n_i) |=> $stable(dac_o));

    // R7: with no word and no strobe edge the output holds
    assert_output_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!vld_i && !(upd_q && !upd_n_i)) |=> $stable(dac_o));

endmodule

// File: rtl/dac_wake_timer.sv
module dac_wake_timer #(
    parameter int WAKE_CYCLES = 2400
) (
    input  logic clk,
    input  logic rst,
    input  logic wake_req_i,
    output logic busy_o
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(WAKE_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (wake_req_i)    cnt_q <= LOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    // R11: the count only ever runs down by one between wake requests
    assert_count_down_R11: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !wake_req_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
    import dac_cmd_pkg::*;
#(
    parameter int RES_BITS    = 16,
    parameter bit MID_RESET   = 1'b0,
    parameter int WAKE_CYCLES = 2400
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [23:0]         word_i,
    input  logic                word_vld_i,
    input  logic                rx_busy_i,
    input  logic                upd_n_i,
    output logic [RES_BITS-1:0] dac_code_o,
    output logic                pwr_dn_o,
    output logic                ready_o
);
    cmd_act_t            act;
    logic [RES_BITS-1:0] code;
    logic                wake_req, settling;

    dac_word_decode #(.RES_BITS(RES_BITS)) u_decode (
        .word_i (word_i),
        .act_o  (act),
        .code_o (code)
    );

    dac_reg_bank #(.RES_BITS(RES_BITS), .MID_RESET(MID_RESET)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .vld_i      (word_vld_i),
        .act_i      (act),
        .code_i     (code),
        .busy_i     (rx_busy_i),
        .upd_n_i    (upd_n_i),
        .dac_o      (dac_code_o),
        .pwr_dn_o   (pwr_dn_o),
        .wake_req_o (wake_req)
    );

    dac_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk        (clk),
        .rst        (rst),
        .wake_req_i (wake_req),
        .busy_o     (settling)
    );

    assign ready_o = ~pwr_dn_o & ~settling;

    // R11: ready is dropped right after leaving sleep
    assert_wake_not_ready_R11: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> (!ready_o && !pwr_dn_o));

    // R11: ready never shows while asleep
    assert_ready_awake_R11: assert property (@(posedge clk) disable iff (rst)
        pwr_dn_o |-> !ready_o);

endmodule

// File: tb/dac_cmd_ctrl_bench.sv
module dac_cmd_ctrl_bench;

    localparam int RES  = 12;
    localparam int WAKE = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [23:0]     word = '0;
    logic            vld = 1'b0;
    logic            busy = 1'b0;
    logic            upd_n = 1'b1;
    logic [RES-1:0]  code;
    logic            pd, rdy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dac_cmd_ctrl #(.RES_BITS(RES), .MID_RESET(1'b1), .WAKE_CYCLES(WAKE)) u_dac_cmd_ctrl (
        .clk        (clk),
        .rst        (rst),
        .word_i     (word),
        .word_vld_i (vld),
        .rx_busy_i  (busy),
        .upd_n_i    (upd_n),
        .dac_code_o (code),
        .pwr_dn_o   (pd),
        .ready_o    (rdy)
    );

    // {word, expected code, expected sleep}
    localparam logic [36:0] VEC [10] = '{
        {24'h00ABC0, 12'h800, 1'b0},   // R3 stage only
        {24'h100000, 12'hABC, 1'b0},   // R4 commit
        {24'h3F1234, 12'h123, 1'b0},   // R5 + R2 ignored bits
        {24'h40FFF0, 12'h123, 1'b1},   // R6 sleep
        {24'hF05550, 12'h123, 1'b1},   // R7 idle
        {24'h706660, 12'h123, 1'b1},   // R7 reserved
        {24'h100000, 12'h123, 1'b0},   // R4 wake, staging kept
        {24'h004560, 12'h123, 1'b0},   // R3
        {24'h200000, 12'h123, 1'b0},   // R7 reserved
        {24'h100000, 12'h456, 1'b0}    // R4
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [23:0] w);
        word = w;
        vld  = 1'b1;
        @(negedge clk);
        vld  = 1'b0;
    endtask

    task automatic strobe_fall();
        upd_n = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 code", 32'(code), 32'h800);
        chk("R1 sleep", 32'(pd), 0);
        chk("R1 ready", 32'(rdy), 1);

        for (int i = 0; i < 10; i++) begin
            send(VEC[i][36:13]);
            chk("R2-R7 table code", 32'(code), 32'(VEC[i][12:1]));
            chk("R2-R7 table sleep", 32'(pd), 32'(VEC[i][0]));
        end

        // R8: strobe edge with a complete word pending
        send(24'h007890);
        chk("R3 stage", 32'(code), 32'h456);
        strobe_fall();
        chk("R8 copy", 32'(code), 32'h789);
        upd_n = 1'b1;
        @(negedge clk);

        // R9 and R11: strobe during transfer wakes only
        send(24'h00AAA0);
        send(24'h400000);
        chk("R6 sleep", 32'(pd), 1);
        chk("R11 asleep not ready", 32'(rdy), 0);
        busy = 1'b1;
        strobe_fall();
        chk("R9 woken", 32'(pd), 0);
        chk("R9 code kept", 32'(code), 32'h789);
        chk("R11 first wake cycle", 32'(rdy), 0);
        repeat (WAKE - 1) @(negedge clk);
        chk("R11 last wake cycle", 32'(rdy), 0);
        @(negedge clk);
        chk("R11 ready again", 32'(rdy), 1);
        upd_n = 1'b1;
        busy  = 1'b0;
        @(negedge clk);
        strobe_fall();
        chk("R8 no pending word", 32'(code), 32'h789);

        // R10: strobe held low as words complete
        send(24'h00DDD0);
        chk("R10 write then update", 32'(code), 32'hDDD);
        send(24'h400000);
        chk("R10 sleep dropped", 32'(pd), 0);
        chk("R10 code", 32'(code), 32'hDDD);
        chk("R10 ready", 32'(rdy), 1);
        upd_n = 1'b1;
        @(negedge clk);

        // R1: reset restores mid-scale
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset again", 32'(code), 32'h800);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule